// File: doc/BRIEF.md
# Clock Source Prescaler and Router

This block sits at the head of a four-group clock distribution section. It picks one of two clock sources, an external clock or an internal oscillator clock. It passes the selected clock through a programmable prescaler with ratio 1 to 6, or it skips the prescaler through a dedicated bypass bit. It then feeds one divider per output group. Each divider can run as a programmable low/high counter or be skipped. A group can also take the selected source straight through, with a total division of one. Configurations that make no sense drive the affected outputs static and raise a single error flag.

The block runs on one fast system clock. Each source arrives as a one-cycle strobe, and each strobe stands for one period of that source. Each group output is a registered one-cycle strobe that marks one period of the divided clock, that is, the rising edge of its high phase. The prescaler also drives a level that shows its high phase. All configuration fields are static inputs. The source switch is a plain multiplexer with no glitch-free handover. No valid/ready interface applies, because there is no data stream and every pin is plain control or status.

Top module: `clk_src_prescale_router`

## Requirements
- R1: While `rst` is high, `grp_tick`, `pre_lvl` and `cfg_err` are all 0 after the next clock edge, whatever the configuration.
- R2: `src_sel` = 2'b00 routes the external strobe `ext_tick` and 2'b10 routes the oscillator strobe `osc_tick`. The unselected strobe has no effect. Codes 2'b01 and 2'b11 are illegal: they set `cfg_err` and keep every group output at 0.
- R3: With the prescaler in use and `pre_code` = R (1 to 6), exactly one distribution tick is produced for every R selected source ticks. A group's total division is R times its own divider ratio.
- R4: With a legal `pre_code` = R and no bypass, `pre_lvl` is high after the source ticks that leave R − floor(R/2) to R − 1 ticks counted in the current prescaler cycle. The level is therefore high for floor(R/2) source periods out of R, and stays low for R = 1.
- R5: Without bypass, `pre_code` 0 or 7 is illegal. `pre_lvl` stays 0, every group output stays 0 (direct groups included), and `cfg_err` is set.
- R6: With `pre_bypass` = 1, `pre_code` is ignored (no error for any code), `pre_lvl` stays 0, and every selected source tick becomes a distribution tick.
- R7: For a group whose divider is active, with low field M and high field N, the output fires on distribution tick M+1 after reset and then once every M+N+2 distribution ticks.
- R8: A group with `ch_bypass` set and no direct routing fires on every distribution tick. This is legal when the prescaler ratio is 2 to 6 or the prescaler is bypassed.
- R9: A prescaler ratio of 1 (code 1, not bypassed) together with a bypassed group divider and no direct routing is illegal. That group's output stays 0 and `cfg_err` is set, and the other groups keep working.
- R10: A group with `direct_en` set fires on every selected source tick, whatever its divider fields. If `pre_bypass` is also set, the group is illegal: its output stays 0 and `cfg_err` is set.
- R11: Each group strobe appears exactly one system clock after the source strobe that completes its period, and never in a cycle that follows a cycle without a source strobe.
- R12: A synchronous reset in mid-run returns the prescaler and group counters to zero. Counting after release starts over exactly as it does after power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | One strobe per external clock period |
| osc_tick | input | 1 | One strobe per oscillator clock period |
| src_sel | input | 2 | Source select: 00 external, 10 oscillator, others illegal |
| pre_bypass | input | 1 | Skip the prescaler |
| pre_code | input | PRE_W | Prescaler ratio code, 1 to PRE_MAX legal |
| ch_bypass | input | NUM_GRP | Per-group divider bypass |
| direct_en | input | NUM_GRP | Per-group direct routing of the selected source |
| ch_low | input | NUM_GRP*HL_W | Per-group low-phase field M, group g at bits g*HL_W upward |
| ch_high | input | NUM_GRP*HL_W | Per-group high-phase field N, same packing |
| grp_tick | output | NUM_GRP | Per-group strobe, one per divided period |
| pre_lvl | output | 1 | Prescaler high-phase level |
| cfg_err | output | 1 | Registered illegal-configuration flag |

## Verification
The bench uses the default parameters: four groups, 4-bit low/high fields, a 3-bit prescaler code and a maximum ratio of 6. With these values the sweep covers every legal prescaler ratio, with and without bypass, against low/high fields at both ends of their range, including swapped M and N. Because the 3-bit code is used in full, both illegal codes 0 and 7 are reachable. One configuration per group gives divide, divider-bypass and direct modes at the same time. This exposes the ratio-1 and bypass-plus-direct illegal cases alongside groups that keep running.

// File: rtl/csr_pkg.sv
package csr_pkg;

  // source select encoding; bit 1 picks the oscillator, bit 0 must be clear
  typedef enum logic [1:0] {
    SRC_EXT_PRE = 2'b00,
    SRC_RSV_A   = 2'b01,
    SRC_OSC_PRE = 2'b10,
    SRC_RSV_B   = 2'b11
  } src_sel_e;

  // resolved behaviour of one output group
  typedef enum logic [1:0] {
    GM_OFF    = 2'b00,
    GM_DIRECT = 2'b01,
    GM_PASS   = 2'b10,
    GM_DIVIDE = 2'b11
  } grp_mode_e;

endpackage

// File: rtl/csr_src_mux.sv
module csr_src_mux
  import csr_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       ext_tick,
  input  logic       osc_tick,
  output logic       sel_tick,
  output logic       sel_ok
);

  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_EXT_PRE: begin
        sel_tick = ext_tick;
        sel_ok   = 1'b1;
      end
      SRC_OSC_PRE: begin
        sel_tick = osc_tick;
        sel_ok   = 1'b1;
      end
      default: begin
        sel_tick = 1'b0;
        sel_ok   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/csr_prescaler.sv
module csr_prescaler #(
  parameter int PRE_W   = 3,
  parameter int PRE_MAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_tick,
  input  logic             bypass,
  input  logic [PRE_W-1:0] code,
  output logic             dist_tick,
  output logic             pre_lvl,
  output logic             code_bad
);

  localparam logic [PRE_W-1:0] MAX_CODE = PRE_W'(PRE_MAX);
  localparam logic [PRE_W-1:0] ONE      = PRE_W'(1);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] half;
  logic             active;
  logic             last;

  assign code_bad = !bypass && ((code == '0) || (code > MAX_CODE));
  assign active   = !bypass && !code_bad;
  assign last     = (cnt_q == code - ONE);
  assign half     = code >> 1;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (src_tick) begin
      cnt_q <= last ? '0 : cnt_q + ONE;
    end
  end

  // bypass forwards every source tick; otherwise one tick per wrap
  assign dist_tick = bypass ? src_tick : (active && src_tick && last);

  // high phase covers the final floor(ratio/2) counts of each cycle
  assign pre_lvl = active && (cnt_q >= code - half);

endmodule

// File: rtl/csr_chan_div.sv
module csr_chan_div
  import csr_pkg::*;
#(
  parameter int HL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dist_tick,
  input  logic            src_tick,
  input  grp_mode_e       mode,
  input  logic [HL_W-1:0] low_m,
  input  logic [HL_W-1:0] high_n,
  output logic            grp_tick
);

  localparam int CNT_W = HL_W + 1;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wrap_at;
  logic [CNT_W-1:0] fire_at;
  logic             nxt_tick;
  logic             tick_q;

  // period M+N+2 counts, so the counter wraps at M+N+1
  assign wrap_at = {1'b0, low_m} + {1'b0, high_n} + C_ONE;
  // rising edge after M+1 low counts
  assign fire_at = {1'b0, low_m};

  always_ff @(posedge clk) begin
    if (rst || (mode != GM_DIVIDE)) begin
      cnt_q <= '0;
    end else if (dist_tick) begin
      cnt_q <= (cnt_q == wrap_at) ? '0 : cnt_q + C_ONE;
    end
  end

  always_comb begin
    case (mode)
      GM_DIRECT: nxt_tick = src_tick;
      GM_PASS:   nxt_tick = dist_tick;
      GM_DIVIDE: nxt_tick = dist_tick && (cnt_q == fire_at);
      default:   nxt_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= nxt_tick;
  end

  assign grp_tick = tick_q;

endmodule

// File: rtl/clk_src_prescale_router.sv
module clk_src_prescale_router
  import csr_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int HL_W    = 4,
  parameter int PRE_W   = 3,
  parameter int PRE_MAX = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ext_tick,
  input  logic                    osc_tick,
  input  logic [1:0]              src_sel,
  input  logic                    pre_bypass,
  input  logic [PRE_W-1:0]        pre_code,
  input  logic [NUM_GRP-1:0]      ch_bypass,
  input  logic [NUM_GRP-1:0]      direct_en,
  input  logic [NUM_GRP*HL_W-1:0] ch_low,
  input  logic [NUM_GRP*HL_W-1:0] ch_high,
  output logic [NUM_GRP-1:0]      grp_tick,
  output logic                    pre_lvl,
  output logic                    cfg_err
);

  logic               sel_tick;
  logic               sel_ok;
  logic               dist_tick;
  logic               code_bad;
  logic               glob_bad;
  logic               ratio_one;
  logic [NUM_GRP-1:0] grp_bad;
  logic               err_q;

  csr_src_mux u_mux (
    .src_sel  (src_sel),
    .ext_tick (ext_tick),
    .osc_tick (osc_tick),
    .sel_tick (sel_tick),
    .sel_ok   (sel_ok)
  );

  csr_prescaler #(
    .PRE_W   (PRE_W),
    .PRE_MAX (PRE_MAX)
  ) u_pre (
    .clk       (clk),
    .rst       (rst),
    .src_tick  (sel_tick),
    .bypass    (pre_bypass),
    .code      (pre_code),
    .dist_tick (dist_tick),
    .pre_lvl   (pre_lvl),
    .code_bad  (code_bad)
  );

  assign glob_bad  = !sel_ok || code_bad;
  assign ratio_one = !pre_bypass && (pre_code == PRE_W'(1));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    grp_mode_e mode;

    // direct routing needs the prescaler path; divider skip needs ratio > 1
    assign grp_bad[g] = direct_en[g] ? pre_bypass : (ch_bypass[g] && ratio_one);

    always_comb begin
      if (glob_bad || grp_bad[g]) mode = GM_OFF;
      else if (direct_en[g])      mode = GM_DIRECT;
      else if (ch_bypass[g])      mode = GM_PASS;
      else                        mode = GM_DIVIDE;
    end

    csr_chan_div #(
      .HL_W (HL_W)
    ) u_div (
      .clk       (clk),
      .rst       (rst),
      .dist_tick (dist_tick),
      .src_tick  (sel_tick),
      .mode      (mode),
      .low_m     (ch_low[g*HL_W +: HL_W]),
      .high_n    (ch_high[g*HL_W +: HL_W]),
      .grp_tick  (grp_tick[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= glob_bad || (|grp_bad);
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/csr_router_check.sv
module csr_router_check #(
  parameter int NUM_GRP = 4,
  parameter int HL_W    = 4,
  parameter int PRE_W   = 3,
  parameter int PRE_MAX = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ext_tick,
  input logic                    osc_tick,
  input logic [1:0]              src_sel,
  input logic                    pre_bypass,
  input logic [PRE_W-1:0]        pre_code,
  input logic [NUM_GRP-1:0]      ch_bypass,
  input logic [NUM_GRP-1:0]      direct_en,
  input logic [NUM_GRP*HL_W-1:0] ch_low,
  input logic [NUM_GRP*HL_W-1:0] ch_high,
  input logic [NUM_GRP-1:0]      grp_tick,
  input logic                    pre_lvl,
  input logic                    cfg_err
);

  localparam logic [PRE_W-1:0] MAX_CODE = PRE_W'(PRE_MAX);

  AST_BAD_SEL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    src_sel[0] |=> cfg_err); // R2

  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pre_bypass && ((pre_code == '0) || (pre_code > MAX_CODE))) |=> (grp_tick == '0)); // R5

  AST_BYPASS_LVL_LOW: assert property (@(posedge clk) disable iff (rst)
    pre_bypass |-> !pre_lvl); // R6

  AST_TICK_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (|grp_tick) |-> $past(ext_tick || osc_tick)); // R11

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    AST_RATIO1_SKIP_STATIC: assert property (@(posedge clk) disable iff (rst)
      (!pre_bypass && (pre_code == PRE_W'(1)) && ch_bypass[g] && !direct_en[g]) |=> !grp_tick[g]); // R9

    AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (direct_en[g] && !pre_bypass && (src_sel == 2'b10) && (pre_code != '0) &&
       (pre_code <= MAX_CODE) && osc_tick) |=> grp_tick[g]); // R10
  end

endmodule

bind clk_src_prescale_router csr_router_check #(
  .NUM_GRP (NUM_GRP),
  .HL_W    (HL_W),
  .PRE_W   (PRE_W),
  .PRE_MAX (PRE_MAX)
) u_chk (.*);

// File: tb/clk_src_prescale_router_tb_top.sv
module clk_src_prescale_router_tb_top;

  localparam int NG = 4;
  localparam int HW = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           ext_tick = 1'b0;
  logic           osc_tick = 1'b0;
  logic [1:0]     t_sel    = 2'b00;
  logic           t_byp    = 1'b0;
  logic [PW-1:0]  t_code   = 3'd1;
  logic [NG-1:0]  t_chb    = '0;
  logic [NG-1:0]  t_dir    = '0;
  logic [HW-1:0]  t_m [NG];
  logic [HW-1:0]  t_n [NG];
  logic [NG*HW-1:0] low_bus;
  logic [NG*HW-1:0] high_bus;

  logic [NG-1:0] grp_tick;
  logic          pre_lvl;
  logic          cfg_err;

  int checks = 0;
  int fails  = 0;
  int scnt   = 0;

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      low_bus[g*HW +: HW]  = t_m[g];
      high_bus[g*HW +: HW] = t_n[g];
    end
  end

  clk_src_prescale_router #(
    .NUM_GRP (NG),
    .HL_W    (HW),
    .PRE_W   (PW),
    .PRE_MAX (6)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ext_tick   (ext_tick),
    .osc_tick   (osc_tick),
    .src_sel    (t_sel),
    .pre_bypass (t_byp),
    .pre_code   (t_code),
    .ch_bypass  (t_chb),
    .direct_en  (t_dir),
    .ch_low     (low_bus),
    .ch_high    (high_bus),
    .grp_tick   (grp_tick),
    .pre_lvl    (pre_lvl),
    .cfg_err    (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit glob_err();
    return t_sel[0] || (!t_byp && ((t_code == 0) || (t_code > 6)));
  endfunction

  function automatic bit grp_err(input int g);
    if (t_dir[g]) return t_byp;
    return t_chb[g] && !t_byp && (t_code == 1);
  endfunction

  function automatic bit exp_err();
    bit e = glob_err();
    for (int g = 0; g < NG; g++) e = e | grp_err(g);
    return e;
  endfunction

  function automatic bit exp_fire(input int g, input int k);
    int r, j, d;
    if (glob_err() || grp_err(g)) return 1'b0;
    if (t_dir[g]) return 1'b1;
    r = int'(t_code);
    if (t_byp) j = k;
    else if (k % r != 0) return 1'b0;
    else j = k / r;
    if (t_chb[g]) return 1'b1;
    d = int'(t_m[g]) + int'(t_n[g]) + 2;
    return (j >= int'(t_m[g]) + 1) && ((j - int'(t_m[g]) - 1) % d == 0);
  endfunction

  function automatic bit exp_lvl(input int k);
    int r, c;
    if (glob_err() || t_byp) return 1'b0;
    r = int'(t_code);
    c = k % r;
    return c >= r - r / 2;
  endfunction

  function automatic string grp_req(input int g);
    if (t_dir[g]) return "R10";
    if (t_chb[g]) return (!t_byp && t_code == 1) ? "R9" : "R8";
    return "R7";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ext_tick = 1'b0;
    osc_tick = 1'b0;
    @(negedge clk);
    // R1 R12: everything quiet while reset is applied
    chk(grp_tick == '0, "R1", int'(grp_tick), 0);
    chk(!pre_lvl, "R12", int'(pre_lvl), 0);
    chk(!cfg_err, "R1", int'(cfg_err), 0);
    rst  = 1'b0;
    scnt = 0;
  endtask

  // which: 0 drives ext_tick, 1 drives osc_tick
  task automatic run_ticks(input int n, input int which);
    bit hit;
    bit ef;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(grp_tick == '0, "R11", int'(grp_tick), 0);
      ext_tick = (which == 0);
      osc_tick = (which == 1);
      @(negedge clk);
      hit = ((which == 0) && (t_sel == 2'b00)) || ((which == 1) && (t_sel == 2'b10));
      if (hit) scnt++;
      for (int g = 0; g < NG; g++) begin
        ef = hit ? exp_fire(g, scnt) : 1'b0;
        chk(grp_tick[g] == ef, grp_req(g), int'(grp_tick[g]), int'(ef));
      end
      chk(pre_lvl == exp_lvl(scnt), "R4", int'(pre_lvl), int'(exp_lvl(scnt)));
      chk(cfg_err == exp_err(), "R9", int'(cfg_err), int'(exp_err()));
      ext_tick = 1'b0;
      osc_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mv[3];
    int nv[2];
    int r, d, n;
    mv = '{0, 2, 15};
    nv = '{0, 7};
    for (int g = 0; g < NG; g++) begin
      t_m[g] = '0;
      t_n[g] = '0;
    end

    // R1: reset with an illegal configuration still clears the flag
    t_sel = 2'b11;
    do_reset();

    // R3 R6 R7 R8 R9 R10: sweep prescaler ratio, bypass and low/high fields
    for (int b = 0; b < 2; b++) begin
      for (int c = 1; c <= 6; c++) begin
        for (int mi = 0; mi < 3; mi++) begin
          for (int ni = 0; ni < 2; ni++) begin
            t_sel  = 2'b00;
            t_byp  = b[0];
            t_code = PW'(c);
            t_chb  = 4'b0010;
            t_dir  = 4'b0100;
            t_m[0] = HW'(mv[mi]); t_n[0] = HW'(nv[ni]);
            t_m[3] = HW'(nv[ni]); t_n[3] = HW'(mv[mi]);
            t_m[1] = HW'(mv[mi]); t_n[1] = HW'(mv[mi]);
            t_m[2] = HW'(nv[ni]); t_n[2] = HW'(nv[ni]);
            do_reset();
            r = (b == 1) ? 1 : c;
            d = mv[mi] + nv[ni] + 2;
            n = r * (((mv[mi] > nv[ni]) ? mv[mi] : nv[ni]) + 1 + d) + 1;
            run_ticks(n, 0);
          end
        end
      end
    end

    // R2: oscillator selected, external strobes have no effect, then osc counts
    t_sel = 2'b10; t_byp = 1'b0; t_code = 3'd2;
    t_chb = 4'b0010; t_dir = 4'b0100;
    t_m[0] = 4'd1; t_n[0] = 4'd2; t_m[3] = 4'd0; t_n[3] = 4'd0;
    do_reset();
    run_ticks(8, 0);
    run_ticks(20, 1);

    // R2: reserved select codes, outputs static and flag raised
    t_sel = 2'b01;
    do_reset();
    run_ticks(6, 0);
    run_ticks(6, 1);
    t_sel = 2'b11;
    do_reset();
    run_ticks(6, 1);

    // R5: illegal prescaler codes without bypass, direct group also static
    t_sel = 2'b00; t_code = 3'd0;
    do_reset();
    run_ticks(10, 0);
    t_code = 3'd7;
    do_reset();
    run_ticks(10, 0);

    // R6: code 7 with bypass is accepted and ignored
    t_byp = 1'b1; t_dir = 4'b0000; t_chb = 4'b0010;
    do_reset();
    run_ticks(12, 0);

    // R12: reset in the middle of a run restarts all counting
    t_byp = 1'b0; t_code = 3'd3; t_chb = 4'b0000; t_dir = 4'b0000;
    t_m[0] = 4'd1; t_n[0] = 4'd2;
    do_reset();
    run_ticks(5, 0);
    chk(pre_lvl == 1'b1, "R12", int'(pre_lvl), 1);
    do_reset();
    run_ticks(24, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule